// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block performs a 32-bit integer division for a processor execute stage. A one-cycle start strobe captures a dividend, a divisor and a per-operation mode bit that selects two's-complement or plain magnitude operands. It returns the quotient together with a one-cycle done pulse. No remainder is produced.

Signed operands are first reduced to magnitudes. A restoring shift-subtract loop then produces one quotient bit per clock, and the sign of the result is corrected at the end, so signed results truncate toward zero.

A zero divisor is caught on the start cycle. The unit then finishes on the next cycle with a zero quotient and a raised carry flag. If the exception enable was high at start, it also raises a one-cycle range-exception request. The overflow flag is never raised. Both flags, like the quotient, are held until the next accepted start.

Top module: `int_div_unit`

## Requirements
- R1: In unsigned mode (mode_signed_i = 0) the quotient is the floor of dividend over divisor, with both operands taken as 32-bit magnitudes (0xfffffff4 / 3 = 0x55555551, 0x0000000c / 0xfffffffd = 0). For a non-zero divisor, busy_o is high for exactly W cycles after the accepting edge. done_o is high for the single cycle that follows.
- R2: In signed mode (mode_signed_i = 1) operands are two's complement and the quotient truncates toward zero. Its sign is the XOR of the operand signs: -11 / 3 = 0xfffffffd, 11 / -3 = 0xfffffffd, -12 / -3 = 4. The case 0x80000000 / -1 returns 0x80000000.
- R3: A zero divisor, in either mode, gives done_o one cycle after the accepting edge. That completion has quotient_o = 0 and carry_o = 1, and no busy period occurs.
- R4: A non-zero divisor completes with carry_o = 0. overflow_o is 0 at all times.
- R5: range_exc_o pulses for one cycle, together with done_o, only when the divisor was zero and exc_en_i was 1 at the accepting edge. In every other case it stays 0.
- R6: A start_i raised while busy_o is high is ignored. The running operation completes with its own result and its own timing.
- R7: quotient_o and carry_o change only on an accepting edge (both cleared) or on the completion edge. Otherwise they hold their value.
- R8: While rst_ni is low, busy_o, done_o, quotient_o, carry_o, overflow_o and range_exc_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when not busy |
| mode_signed_i | input | 1 | 1 = two's-complement operands, 0 = magnitudes |
| exc_en_i | input | 1 | Enables the range-exception request on a zero divisor |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Quotient, held until the next accepted start |
| carry_o | output | 1 | Divide-by-zero flag |
| overflow_o | output | 1 | Overflow flag, always 0 |
| range_exc_o | output | 1 | One-cycle range-exception request |

## Verification
The assertions assume three things about the inputs:
- start_i, mode_signed_i, exc_en_i and the operands are sampled only on an accepting edge;
- nothing needs to stay stable afterwards;
- a start raised during a busy period must have no visible effect.

The stimulus drives every input on the falling edge, so each value is stable across the rising edge that samples it. It deliberately pulses start_i, with a zero divisor and the enable set, in the middle of a busy period. That stray start exercises R6 and still stays within what the checker treats as legal.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         mode_signed_i,
  output logic [W-1:0] mag_dd_o,
  output logic [W-1:0] mag_dv_o,
  output logic         neg_q_o,
  output logic         dv_zero_o
);
  logic dd_neg, dv_neg;

  assign dd_neg    = mode_signed_i & dividend_i[W-1];
  assign dv_neg    = mode_signed_i & divisor_i[W-1];
  // most-negative value maps onto itself, which is the right unsigned magnitude
  assign mag_dd_o  = dd_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_dv_o  = dv_neg ? (~divisor_i + 1'b1) : divisor_i;
  assign neg_q_o   = dd_neg ^ dv_neg;
  assign dv_zero_o = (divisor_i == '0);
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mag_dd_i,
  input  logic [W-1:0] mag_dv_i,
  output logic [W-1:0] quo_next_o
);
  logic [W-1:0] rem_q, quo_q, dv_q;
  logic [W:0]   rem_sh, diff;
  logic [W-1:0] rem_next;
  logic         fits;

  // restoring step: shift in next dividend bit, try subtract
  assign rem_sh     = {rem_q, quo_q[W-1]};
  assign diff       = rem_sh - {1'b0, dv_q};
  assign fits       = ~diff[W];
  assign rem_next   = fits ? diff[W-1:0] : rem_sh[W-1:0];
  assign quo_next_o = {quo_q[W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dv_q  <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= mag_dd_i;
      dv_q  <= mag_dv_i;
    end else if (step_i) begin
      rem_q <= rem_next;
      quo_q <= quo_next_o;
    end
  end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] mag_i,
  input  logic         neg_i,
  output logic [W-1:0] res_o
);
  assign res_o = neg_i ? (~mag_i + 1'b1) : mag_i;
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_signed_i,
  input  logic         exc_en_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic         carry_o,
  output logic         overflow_o,
  output logic         range_exc_o
);
  localparam int CW = $clog2(W + 1);

  div_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic         neg_q, done_q, exc_q, carry_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] mag_dd, mag_dv, quo_next, quo_fixed;
  logic         neg_sel, dv_zero, accept, last_step;

  assign accept    = start_i & (state_q == ST_IDLE);
  assign last_step = (state_q == ST_RUN) & (cnt_q == CW'(1));

  div_operand_prep #(.W(W)) u_prep (
    .dividend_i   (dividend_i),
    .divisor_i    (divisor_i),
    .mode_signed_i(mode_signed_i),
    .mag_dd_o     (mag_dd),
    .mag_dv_o     (mag_dv),
    .neg_q_o      (neg_sel),
    .dv_zero_o    (dv_zero)
  );

  div_core #(.W(W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept & ~dv_zero),
    .step_i    (state_q == ST_RUN),
    .mag_dd_i  (mag_dd),
    .mag_dv_i  (mag_dv),
    .quo_next_o(quo_next)
  );

  div_sign_fix #(.W(W)) u_fix (
    .mag_i(quo_next),
    .neg_i(neg_q),
    .res_o(quo_fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      carry_q <= 1'b0;
      quo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      if (accept) begin
        carry_q <= dv_zero;
        quo_q   <= '0;
        neg_q   <= neg_sel;
        if (dv_zero) begin
          // finish at once, no iteration
          done_q <= 1'b1;
          exc_q  <= exc_en_i;
        end else begin
          state_q <= ST_RUN;
          cnt_q   <= CW'(W);
        end
      end else if (state_q == ST_RUN) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_step) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          quo_q   <= quo_fixed;
        end
      end
    end
  end

  assign busy_o      = (state_q == ST_RUN);
  assign done_o      = done_q;
  assign quotient_o  = quo_q;
  assign carry_o     = carry_q;
  assign overflow_o  = 1'b0;
  assign range_exc_o = exc_q;
endmodule

// File: rtl/int_div_unit_chk.sv
module int_div_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         exc_en_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic         carry_o,
  input logic         range_exc_o
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] busy_len;
  logic          zero_seen, en_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len  <= '0;
      zero_seen <= 1'b0;
      en_seen   <= 1'b0;
    end else begin
      busy_len <= busy_o ? busy_len + 1'b1 : '0;
      if (start_i && !busy_o) begin
        zero_seen <= (divisor_i == '0);
        en_seen   <= exc_en_i;
      end
    end
  end

  a_r1_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> (busy_len == LW'(W)));

  a_r3_zero_quotient: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && carry_o) |-> (quotient_o == '0));

  a_r4_carry_matches_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (carry_o == zero_seen));

  a_r5_exc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_exc_o |-> (done_o && carry_o));

  a_r5_exc_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && carry_o) |-> (range_exc_o == en_seen));

  a_r6_busy_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(carry_o)));
endmodule

bind int_div_unit int_div_unit_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .exc_en_i   (exc_en_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .carry_o    (carry_o),
  .range_exc_o(range_exc_o)
);

// File: tb/int_div_unit_bench.sv
`timescale 1ns/1ps
module int_div_unit_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sgn = 1'b0, en = 1'b0;
  logic [W-1:0] dd = '0, dv = '0;
  logic busy, done, cy, ov, exc;
  logic [W-1:0] quo;

  int n_tests = 0, n_fail = 0, cycles = 0;

  // reference model state
  bit         m_busy = 0, m_done = 0, m_cy = 0, m_exc = 0;
  logic [W-1:0] m_q = '0, m_res = '0;
  int         m_cnt = 0;
  string      m_tag = "R1";

  always #2 clk = ~clk;

  int_div_unit #(.W(W)) u_int_div_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_signed_i(sgn),
    .exc_en_i(en), .dividend_i(dd), .divisor_i(dv), .busy_o(busy),
    .done_o(done), .quotient_o(quo), .carry_o(cy), .overflow_o(ov),
    .range_exc_o(exc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input bit s);
    int sa, sb;
    if (!s) return a / b;
    sa = a; sb = b;
    if (sa == int'(32'h8000_0000) && sb == -1) return 32'h8000_0000;
    return W'(sa / sb);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        m_done = 0; m_exc = 0;
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_q = m_res; end
      end else begin
        m_done = 0; m_exc = 0;
        if (start) begin
          m_q = '0;
          if (dv == '0) begin
            m_done = 1; m_cy = 1; m_exc = en; m_tag = "R3";
          end else begin
            m_busy = 1; m_cnt = W; m_cy = 0;
            m_res = ref_div(dd, dv, sgn);
            m_tag = sgn ? "R2" : "R1";
          end
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R1", "busy", W'(busy), W'(m_busy));
      chk(done == m_done, "R1", "done", W'(done), W'(m_done));
      chk(quo == m_q, m_done ? m_tag : "R7", "quotient", quo, m_q);
      chk(cy == m_cy, m_cy ? "R3" : "R4", "carry", W'(cy), W'(m_cy));
      chk(ov == 1'b0, "R4", "overflow", W'(ov), '0);
      chk(exc == m_exc, "R5", "range_exc", W'(exc), W'(m_exc));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit s, input bit e);
    @(negedge clk);
    dd = a; dv = b; sgn = s; en = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!busy && !done && !cy && !ov && !exc, "R8", "flags in reset",
        {27'b0, busy, done, cy, ov, exc}, '0);
    chk(quo == '0, "R8", "quotient in reset", quo, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1 unsigned
    run_op(32'h0000000c, 32'h3, 0, 0);
    run_op(32'h0000000b, 32'h3, 0, 0);
    run_op(32'hfffffff4, 32'hfffffffd, 0, 0);
    run_op(32'hfffffff4, 32'h3, 0, 0);
    run_op(32'hfffffff5, 32'h3, 0, 0);
    run_op(32'h0000000c, 32'hfffffffd, 0, 0);
    run_op(32'hffffffff, 32'h1, 0, 1);
    // R2 signed
    run_op(32'h0000000c, 32'h3, 1, 0);
    run_op(32'hfffffff5, 32'hfffffffd, 1, 0);
    run_op(32'hfffffff4, 32'hfffffffd, 1, 0);
    run_op(32'hfffffff5, 32'h3, 1, 0);
    run_op(32'h0000000b, 32'hfffffffd, 1, 0);
    run_op(32'h80000000, 32'hffffffff, 1, 1);
    run_op(32'h80000000, 32'h1, 1, 0);
    // R3 / R5 zero divisor, both modes, enable low and high
    run_op(32'h0000000c, 32'h0, 0, 0);
    run_op(32'hfffffff4, 32'h0, 1, 0);
    run_op(32'h0000000c, 32'h0, 1, 1);
    run_op(32'hfffffff4, 32'h0, 0, 1);

    // R6: stray start mid-operation with zero divisor and enable set
    @(negedge clk);
    dd = 32'h00000064; dv = 32'h7; sgn = 0; en = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    dv = '0; en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(quo == 32'd14 && !cy, "R6", "result after stray start", quo, 32'd14);

    // R7: outputs held for idle cycles
    repeat (6) @(negedge clk);
    chk(quo == 32'd14, "R7", "held quotient", quo, 32'd14);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 9) == 0) ? '0 : ($urandom >> $urandom_range(0, 31));
      run_op(a, b, $urandom_range(0, 1), $urandom_range(0, 1));
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule